// File: doc/BRIEF.md
# Angle Hold Latch with Byte-Wise Readout

This block keeps a 16-bit tracking angle counter and gives a host on an 8-bit bus a coherent copy of it. The counter moves by one count on each up or down step pulse and never stops. A hold register normally follows the counter on every clock. When the host pulls the active-low inhibit line low, the hold register freezes, and the host can read the frozen word one byte at a time. Counting goes on underneath the whole time. When inhibit returns high, the hold register catches up with the live count on the next edge.

Two active-low byte enables pick which half of the held word goes onto the bus. The bus path is registered, so the output-enable and the data follow the enables one clock later. When no byte is selected, the bus is released: the output-enable is low and the data lines read zero, which stands in for high impedance at the pad.

The hold path is a two-state machine. In TRACK the register loads the next counter value on every edge. The transition TRACK->HOLD happens at the first edge where inhibit is sampled low, and that edge still loads the updated count. HOLD keeps the register unchanged. The transition HOLD->TRACK happens at the first edge where inhibit is sampled high, and that edge loads the updated count. The readout machine has three states: RD_IDLE (bus released), RD_HIGH (upper byte driven) and RD_LOW (lower byte driven). At each edge it moves to RD_HIGH if the high enable is low, otherwise to RD_LOW if the low enable is low, otherwise to RD_IDLE.

Top module: `angrd_latch_reader`

## Requirements
- R1: While reset is asserted, the held word is 0, the output-enable is 0 and the bus reads 0.
- R2: The counter goes up by one on an edge where only the up step is high and down by one where only the down step is high. Both steps high, or neither, leave it unchanged. It wraps modulo 2^16, so one down step from 0 gives 0xFFFF.
- R3: While inhibit is sampled high, the held word after each edge equals the counter value after that edge.
- R4: While in HOLD with inhibit low, the held word stays unchanged whatever the step inputs do.
- R5: At the edge where inhibit is first sampled low, the held word takes the counter value after that edge's step, so valid held data is present one clock after inhibit is sampled low.
- R6: Inhibit never affects counting. At the first edge after release, the held word equals the start count plus every step taken during the hold.
- R7: One clock after the high enable is sampled low, the output-enable is 1 and the bus carries held bits 15..8 (the most significant byte).
- R8: One clock after only the low enable is sampled low, the output-enable is 1 and the bus carries held bits 7..0.
- R9: When both enables are low in the same cycle, the high byte is driven.
- R10: One clock after both enables are sampled high, the output-enable is 0 and the bus reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up_i | input | 1 | Count-up step pulse |
| step_dn_i | input | 1 | Count-down step pulse |
| inhibit_n_i | input | 1 | Active-low freeze of the hold register |
| en_hi_n_i | input | 1 | Active-low enable for the upper byte |
| en_lo_n_i | input | 1 | Active-low enable for the lower byte |
| bus_o | output | 8 | Byte driven to the host bus (0 when released) |
| bus_oe_o | output | 1 | Bus output-enable |
| held_o | output | 16 | Debug view of the held word |

## Verification
A hold machine stuck in TRACK shows up on the first step taken during an inhibit: the held word visibly advances one clock later. A machine stuck in HOLD shows up on release, when the held word fails to jump to the live count one clock later. A counter disturbed by inhibit is caught on release, because the held word then differs from the start count plus the steps taken. A wrong readout state appears on the bus one clock after the enables change: the wrong byte is driven, or the output-enable is wrong, or priority is lost when both enables are low.

// File: rtl/angrd_pkg.sv
package angrd_pkg;
    typedef enum logic {
        LS_TRACK = 1'b0,
        LS_HOLD  = 1'b1
    } lat_state_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'b00,
        RD_HIGH = 2'b01,
        RD_LOW  = 2'b10
    } rd_state_t;
endpackage

// File: rtl/angrd_track_cnt.sv
module angrd_track_cnt #(
    parameter int ANG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [ANG_W-1:0] cnt_q,
    output logic [ANG_W-1:0] cnt_nxt
);
    localparam logic [ANG_W-1:0] ONE = ANG_W'(1);

    always_comb begin
        unique case ({step_up, step_dn})
            2'b10:   cnt_nxt = cnt_q + ONE;
            2'b01:   cnt_nxt = cnt_q - ONE;
            default: cnt_nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn) |=> cnt_q == $past(cnt_q) + ONE); // R2
    AST_CNT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !step_up) |=> cnt_q == $past(cnt_q) - ONE); // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up == step_dn) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/angrd_hold_latch.sv
module angrd_hold_latch
    import angrd_pkg::*;
#(
    parameter int ANG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit_n,
    input  logic [ANG_W-1:0] cnt_q,
    input  logic [ANG_W-1:0] cnt_nxt,
    output logic [ANG_W-1:0] held_q
);
    lat_state_t state_q;

    // state register: records where inhibit was last sampled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_TRACK;
        else        state_q <= inhibit_n ? LS_TRACK : LS_HOLD;
    end

    // output register: the entry edge into HOLD still loads the update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            unique case (state_q)
                LS_TRACK: held_q <= cnt_nxt;
                LS_HOLD:  if (inhibit_n) held_q <= cnt_nxt;
                default:  held_q <= held_q;
            endcase
        end
    end

    AST_TRACK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_n |=> held_q == cnt_q); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HOLD && !inhibit_n) |=> $stable(held_q)); // R4
    AST_CAPTURE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_TRACK && !inhibit_n) |=> held_q == cnt_q); // R5
endmodule

// File: rtl/angrd_byte_readout.sv
module angrd_byte_readout
    import angrd_pkg::*;
#(
    parameter int ANG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_hi_n,
    input  logic              en_lo_n,
    input  logic [ANG_W-1:0]  held_q,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe
);
    localparam int NBYTE = ANG_W / BYTE_W;

    logic [BYTE_W-1:0] byte_v [NBYTE];
    rd_state_t rd_q;

    for (genvar g = 0; g < NBYTE; g++) begin : g_slice
        assign byte_v[g] = held_q[g*BYTE_W +: BYTE_W];
    end

    // state register: high byte wins when both enables are low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_q <= RD_IDLE;
        else if (!en_hi_n) rd_q <= RD_HIGH;
        else if (!en_lo_n) rd_q <= RD_LOW;
        else               rd_q <= RD_IDLE;
    end

    // outputs
    always_comb begin
        unique case (rd_q)
            RD_HIGH: begin bus_o = byte_v[NBYTE-1]; bus_oe = 1'b1; end
            RD_LOW:  begin bus_o = byte_v[0];       bus_oe = 1'b1; end
            default: begin bus_o = '0;              bus_oe = 1'b0; end
        endcase
    end

    AST_HI_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_hi_n |=> bus_oe && bus_o == held_q[ANG_W-1 -: BYTE_W]); // R7 R9
    AST_LO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi_n && !en_lo_n) |=> bus_oe && bus_o == held_q[BYTE_W-1:0]); // R8
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi_n && en_lo_n) |=> !bus_oe && bus_o == '0); // R10
    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |-> !bus_oe && bus_o == '0); // R1
endmodule

// File: rtl/angrd_latch_reader.sv
module angrd_latch_reader #(
    parameter int ANG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up_i,
    input  logic              step_dn_i,
    input  logic              inhibit_n_i,
    input  logic              en_hi_n_i,
    input  logic              en_lo_n_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic [ANG_W-1:0]  held_o
);
    logic [ANG_W-1:0] cnt_q;
    logic [ANG_W-1:0] cnt_nxt;

    angrd_track_cnt #(.ANG_W(ANG_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (step_up_i),
        .step_dn (step_dn_i),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    angrd_hold_latch #(.ANG_W(ANG_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit_n (inhibit_n_i),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .held_q    (held_o)
    );

    angrd_byte_readout #(.ANG_W(ANG_W), .BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_hi_n (en_hi_n_i),
        .en_lo_n (en_lo_n_i),
        .held_q  (held_o),
        .bus_o   (bus_o),
        .bus_oe  (bus_oe_o)
    );
endmodule

// File: tb/test_angrd_latch_reader.sv
module test_angrd_latch_reader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b0, dn = 1'b0, inh_n = 1'b1, ehi_n = 1'b1, elo_n = 1'b1;
    logic [7:0]  bus;
    logic        oe;
    logic [15:0] held;

    int checks = 0;
    int errors = 0;

    logic [15:0] cnt_m = 16'h0000;
    logic [15:0] held_m = 16'h0000;
    logic        hold_m = 1'b0;

    always #4 clk = ~clk;

    angrd_latch_reader i_angrd_latch_reader (
        .clk(clk), .rst_n(rst_n), .step_up_i(up), .step_dn_i(dn),
        .inhibit_n_i(inh_n), .en_hi_n_i(ehi_n), .en_lo_n_i(elo_n),
        .bus_o(bus), .bus_oe_o(oe), .held_o(held)
    );

    // vector fields: [4] inhibit_n, [3] up, [2] down, [1] high enable_n, [0] low enable_n
    localparam logic [4:0] VEC [20] = '{
        5'b10111, 5'b11011, 5'b11001, 5'b11010, 5'b11100,
        5'b01011, 5'b01011, 5'b00111, 5'b01001, 5'b01010,
        5'b01000, 5'b11011, 5'b11010, 5'b10101, 5'b10011,
        5'b00011, 5'b01101, 5'b11110, 5'b10111, 5'b11011
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] v);
        logic [15:0] nxt;
        logic        was_hold;
        string       htag, btag;
        logic [7:0]  bexp;
        logic        oexp;
        inh_n = v[4]; up = v[3]; dn = v[2]; ehi_n = v[1]; elo_n = v[0];
        nxt = cnt_m;
        if (up && !dn) nxt = cnt_m + 16'd1;
        if (dn && !up) nxt = cnt_m - 16'd1;
        was_hold = hold_m;
        if (!was_hold || inh_n) held_m = nxt;
        cnt_m  = nxt;
        hold_m = !inh_n;
        if (inh_n && was_hold)  htag = "R6 held after release";
        else if (inh_n)         htag = "R2 R3 held tracks counter";
        else if (!was_hold)     htag = "R5 capture on inhibit";
        else                    htag = "R4 held frozen";
        if (!ehi_n && !elo_n)   begin btag = "R9 both enables"; bexp = held_m[15:8]; oexp = 1'b1; end
        else if (!ehi_n)        begin btag = "R7 high byte";    bexp = held_m[15:8]; oexp = 1'b1; end
        else if (!elo_n)        begin btag = "R8 low byte";     bexp = held_m[7:0];  oexp = 1'b1; end
        else                    begin btag = "R10 released";    bexp = 8'h00;        oexp = 1'b0; end
        @(posedge clk);
        @(negedge clk);
        chk(htag, held, held_m);
        chk(btag, {8'h00, bus}, {8'h00, bexp});
        chk({btag, " oe"}, {15'h0, oe}, {15'h0, oexp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        chk("R1 held in reset", held, 16'h0000);
        chk("R1 bus in reset", {8'h00, bus}, 16'h0000);
        chk("R1 oe in reset", {15'h0, oe}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 20; i++) apply(VEC[i]);

        // directed: climb to a count with a nonzero high byte
        for (int i = 0; i < 421; i++) apply(5'b11011);
        apply(5'b01011);                 // R5 capture with simultaneous step
        for (int i = 0; i < 37; i++) apply(5'b01011); // R4 hold while counting
        apply(5'b00101);                 // R7 high byte of frozen word
        apply(5'b00110);                 // R8 low byte
        apply(5'b00100);                 // R9 priority
        apply(5'b10011);                 // R6 release reflects all steps
        apply(5'b11101);                 // R7 live high byte while tracking

        // R1: reset in the middle of operation
        @(negedge clk);
        inh_n = 1'b1; up = 1'b1; dn = 1'b0; ehi_n = 1'b0; elo_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 held mid-run reset", held, 16'h0000);
        chk("R1 oe mid-run reset", {15'h0, oe}, 16'h0000);
        chk("R1 bus mid-run reset", {8'h00, bus}, 16'h0000);
        cnt_m = 16'h0000; held_m = 16'h0000; hold_m = 1'b0;
        up = 1'b0; ehi_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        apply(5'b10111);                 // R2 wrap below zero
        apply(5'b11111);                 // R2 both steps hold count

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule